// File: doc/BRIEF.md
# Incremental Digital PID Compensator

This block closes the digital side of a sampled power-converter loop. On each sampling strobe, once per switching period, it takes a feedback code from the converter's ADC and a reference code in the same units, and forms the signed error from them. It then advances a velocity-form control law. The new output is the previous output plus three weighted error terms: the current error, the error one sample back and the error two samples back. The weights are programmable signed fixed-point values.

The result is clamped to the duty range and stored as the next sample's previous output. It reaches the duty output only at the following strobe. This one-sample delay models the acquisition, conversion and compute latency as a single sample. A PWM stage reads the command, which holds steady for the whole interval. A one-cycle valid flag marks each latch.

Top module: `pid_incr`

## Requirements
- R1: A synchronous active-high reset forces `duty_cmd` to 0 and `duty_vld` to 0. It also clears the stored previous output and both stored past errors to 0.
- R2: The error is `ref_code - adc_code`, taken as unsigned codes and held as an 11-bit signed value. A reference step, for example from 110 to 130 with the feedback at 110, appears as a step in the error.
- R3: On each strobe the new output is u = u_prev + floor((A*e0 + B*e1 + C*e2) / 4096). Here e0 is the current error, e1 and e2 are the errors from the two previous strobes, and u_prev is the stored previous output.
- R4: The coefficients `coef_a`, `coef_b` and `coef_c` are 16-bit two's-complement Q4.12 values, so fractional and negative gains are allowed (3.4 is 13926, -6.15 is -25190).
- R5: The output computed at a strobe appears on `duty_cmd` one cycle after the next strobe. The first strobe after reset therefore presents 0.
- R6: `duty_cmd` changes only in the cycle after a strobe and otherwise holds its value.
- R7: `duty_vld` is high for exactly the one cycle after each strobe and is low at all other times.
- R8: The computed output is clamped to 0..511 before it is stored, so a saturated loop recovers at once when the error reverses.
- R9: While `sample_stb` is low, changes on `adc_code`, `ref_code` and the coefficients leave the output and the stored history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-cycle strobe per sampling period |
| adc_code | input | 10 | Feedback sample, unsigned |
| ref_code | input | 10 | Reference code, unsigned |
| coef_a | input | 16 | Gain on the current error, Q4.12 signed |
| coef_b | input | 16 | Gain on the error one sample back, Q4.12 signed |
| coef_c | input | 16 | Gain on the error two samples back, Q4.12 signed |
| duty_cmd | output | 9 | Duty command to the PWM stage |
| duty_vld | output | 1 | Pulse marking a newly latched command |

## Verification
The hardest case to reach is recovery from saturation. It needs the stored output pinned at 511 or 0 and then an error reversal, so that the next command is built from the clamped value rather than from a wound-up sum. The stimulus gets there by driving a large positive error under the fast gain set until the output saturates high, and then reversing the error. The scoreboard models every output through the one-sample delay. It also changes the inputs between strobes to show they are ignored.

// File: rtl/pid_incr.sv
module pid_incr #(
  parameter int ADC_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 12,
  parameter int DUTY_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_stb,
  input  logic [ADC_W-1:0]         adc_code,
  input  logic [ADC_W-1:0]         ref_code,
  input  logic signed [COEF_W-1:0] coef_a,
  input  logic signed [COEF_W-1:0] coef_b,
  input  logic signed [COEF_W-1:0] coef_c,
  output logic [DUTY_W-1:0]        duty_cmd,
  output logic                     duty_vld
);
  localparam int ERR_W = ADC_W + 1;
  localparam int ACC_W = COEF_W + ERR_W + 3;
  localparam int PAD_W = ACC_W - DUTY_W - FRAC_W;

  logic signed [ERR_W-1:0] err_now, err_d1, err_d2;
  logic signed [ACC_W-1:0] p_a, p_b, p_c, u_ext, acc, acc_int;
  logic [DUTY_W-1:0]       u_prev, u_next;
  logic                    neg, over;

  assign err_now = $signed({1'b0, ref_code}) - $signed({1'b0, adc_code});

  assign p_a = ACC_W'(coef_a) * ACC_W'(err_now);
  assign p_b = ACC_W'(coef_b) * ACC_W'(err_d1);
  assign p_c = ACC_W'(coef_c) * ACC_W'(err_d2);

  assign u_ext   = $signed({{PAD_W{1'b0}}, u_prev, {FRAC_W{1'b0}}});
  assign acc     = u_ext + p_a + p_b + p_c;
  assign acc_int = acc >>> FRAC_W;

  assign neg  = acc_int[ACC_W-1];
  assign over = |acc_int[ACC_W-2:DUTY_W];

  always_comb begin
    if (neg)       u_next = '0;
    else if (over) u_next = '1;
    else           u_next = acc_int[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_prev   <= '0;
      err_d1   <= '0;
      err_d2   <= '0;
      duty_cmd <= '0;
      duty_vld <= 1'b0;
    end else begin
      duty_vld <= sample_stb;
      if (sample_stb) begin
        duty_cmd <= u_prev;
        u_prev   <= u_next;
        err_d1   <= err_now;
        err_d2   <= err_d1;
      end
    end
  end
endmodule

// File: rtl/pid_incr_chk.sv
module pid_incr_chk #(
  parameter int DUTY_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_stb,
  input logic [DUTY_W-1:0] duty_cmd,
  input logic              duty_vld
);
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (duty_cmd == '0 && !duty_vld));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sample_stb)) |-> $stable(duty_cmd));

  p_vld_follows_r7: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> duty_vld);

  p_vld_only_after_r7: assert property (@(posedge clk) disable iff (rst)
    duty_vld |-> $past(sample_stb));

  p_change_flagged_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_cmd) |-> duty_vld);
endmodule

bind pid_incr pid_incr_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb),
  .duty_cmd(duty_cmd), .duty_vld(duty_vld)
);

// File: tb/pid_incr_bench.sv
module pid_incr_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_stb = 1'b0;
  logic [9:0] adc_code = '0, ref_code = '0;
  logic signed [15:0] coef_a = '0, coef_b = '0, coef_c = '0;
  logic [8:0] duty_cmd;
  logic duty_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_incr u_pid_incr (
    .clk(clk), .rst(rst), .sample_stb(sample_stb),
    .adc_code(adc_code), .ref_code(ref_code),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .duty_cmd(duty_cmd), .duty_vld(duty_vld)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int m_pend = 0, m_e1 = 0, m_e2 = 0;
  int last_cmd = 0;
  bit done = 0;

  task automatic model_reset();
    m_pend = 0; m_e1 = 0; m_e2 = 0;
  endtask

  task automatic do_sample(input int r, input int a, input string tag, input int gap);
    int e, sum, t;
    e = r - a;
    exp_q.push_back(m_pend);
    tag_q.push_back(tag);
    sum = int'(coef_a) * e + int'(coef_b) * m_e1 + int'(coef_c) * m_e2;
    t = m_pend + (sum >>> 12);
    if (t < 0) t = 0;
    if (t > 511) t = 511;
    m_pend = t; m_e2 = m_e1; m_e1 = e;
    ref_code = 10'(r); adc_code = 10'(a); sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst) last_cmd = 0;
    else if (duty_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7: valid with no strobe, actual %0d expected none", duty_cmd);
      end else begin
        int ex; string tg;
        ex = exp_q.pop_front(); tg = tag_q.pop_front();
        if (int'(duty_cmd) != ex) begin
          fails++;
          $display("FAIL %s: duty_cmd actual %0d expected %0d", tg, duty_cmd, ex);
        end
      end
      last_cmd = int'(duty_cmd);
    end else begin
      checks++;
      if (int'(duty_cmd) != last_cmd) begin
        fails++;
        $display("FAIL R6: duty_cmd moved without strobe, actual %0d expected %0d", duty_cmd, last_cmd);
      end
    end
  end

  task automatic check_reset();
    checks++;
    if (duty_cmd != 9'd0 || duty_vld != 1'b0) begin
      fails++;
      $display("FAIL R1: after reset actual cmd=%0d vld=%0d expected cmd=0 vld=0", duty_cmd, duty_vld);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (exp_q.size() != 0) begin
        fails++;
        $display("FAIL R7: %0d outputs missing, actual 0 expected %0d", exp_q.size(), exp_q.size());
      end
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset();

    // R4 fast gain set, R2 setpoint step 110 -> 130, R5 first output 0
    coef_a = 16'sd13926; coef_b = -16'sd25190; coef_c = 16'sd12001;
    do_sample(110, 110, "R5", 1);
    do_sample(130, 110, "R2", 2);
    for (int i = 0; i < 6; i++) do_sample(130, 110 + 3*i, "R3", 1);

    // R9 inputs toggled without a strobe
    ref_code = 10'd900; adc_code = 10'd3; coef_a = 16'sd30000;
    repeat (4) @(negedge clk);
    coef_a = 16'sd13926;
    do_sample(125, 120, "R9", 1);

    // R8 drive to high saturation, then reverse
    for (int i = 0; i < 6; i++) do_sample(1000, 0, "R8", 1);
    do_sample(0, 1000, "R8", 1);
    do_sample(0, 1000, "R8", 1);
    for (int i = 0; i < 6; i++) do_sample(0, 1023, "R8", 1);
    do_sample(600, 0, "R8", 1);
    do_sample(600, 0, "R8", 1);

    // R4 slow gain set, back-to-back strobes
    coef_a = 16'sd6226; coef_b = -16'sd11510; coef_c = 16'sd5652;
    for (int i = 0; i < 8; i++) do_sample(130, 100 + 4*i, "R3", 0);
    @(negedge clk);

    // R1 reset mid-run clears history
    rst = 1'b1; model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset();
    do_sample(200, 100, "R1", 1);
    do_sample(200, 150, "R1", 1);
    do_sample(200, 190, "R1", 3);
    finish_run();
  end
endmodule